// File: doc/BRIEF.md
# Four-Flag Status Register

This block stores the four condition flags of a small 8-bit processor: carry, zero, negative and equal. Each clock cycle it does one of three things. It captures a fresh flag set made from the current ALU operation, or it loads the flags from the low nibble of the data bus, or it keeps its value. A small helper inside the block works out zero, negative and equal from the ALU result and the two ALU operands. The carry comes straight from the ALU carry output.

The stored flags are always visible to the branch-condition logic, and the carry bit is fed back to the ALU as its carry input. When the read-out command is asserted, the flags are placed on the data bus with the upper nibble forced to zero, so that software can push them to the stack or use them as an operand. The two load commands share one internal path. If both are raised in the same cycle, the path is not driven, the register keeps its value and a conflict output is raised for that cycle.

The load path is chosen by an enumerated source selector with four named cases. HOLD is the case where no load is asked for. FROM_ALU is a load from the ALU only. FROM_BUS is a load from the bus only. CLASH is the case where both loads are asked for. Each clock edge ends in one of these cases, and the next edge decides again from scratch.

Top module: `status_flags`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all four flags to 0.
- R2: With alu_load high and bus_load low, at the next rising edge the flags take these values: carry = alu_carry, zero = (alu_result == 0x00), negative = alu_result[7], and equal = (alu_opa == alu_opb).
- R3: With bus_load high and alu_load low, at the next rising edge the flags take bus_in[3:0]. Bits bus_in[7:4] are ignored.
- R4: With both alu_load and bus_load high, conflict is 1 in that cycle and the flags keep their value across the next edge. In every other cycle conflict is 0.
- R5: With neither load high, the flags keep their value.
- R6: While flag_drive is high, bus_out = {4'b0000, flags} and bus_oe = 1. While it is low, bus_out = 0 and bus_oe = 0. Driving the bus never changes the flags.
- R7: The bit layout of flags_out and of the bus is carry in bit 0, zero in bit 1, negative in bit 2 and equal in bit 3. carry_to_alu always equals the stored carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_load | input | 1 | Capture flags from the current ALU operation |
| alu_result | input | 8 | ALU result |
| alu_opa | input | 8 | ALU operand A |
| alu_opb | input | 8 | ALU operand B |
| alu_carry | input | 1 | ALU carry output |
| bus_load | input | 1 | Load flags from the data bus |
| bus_in | input | 8 | Data bus value seen by the block |
| flag_drive | input | 1 | Put the flags on the data bus |
| bus_out | output | 8 | Flags as a bus byte, upper nibble zero |
| bus_oe | output | 1 | Bus output enable |
| flags_out | output | 4 | Stored flags for the branch-condition logic |
| carry_to_alu | output | 1 | Stored carry, fed back to the ALU |
| conflict | output | 1 | Both load commands asserted this cycle |

## Verification
A flag that is stored wrongly shows on flags_out one cycle after the load that caused it, since the register is the only storage on the way. The same wrong bit appears on bus_out in any cycle where flag_drive is high. A wrong hold decision appears as a change of flags_out after an idle or clashing cycle. Because the bench keeps a model of the flags and compares against it after every edge, a wrong state is seen in the cycle it appears, and a stale value cannot hide until a later load overwrites it.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;

    localparam int FLAG_W = 4;

    // Field order fixes the bit layout: eq=3, neg=2, zero=1, carry=0
    typedef struct packed {
        logic eq;
        logic neg;
        logic zero;
        logic carry;
    } flags_t;

    typedef enum logic [1:0] {
        SRC_HOLD     = 2'd0,
        SRC_FROM_ALU = 2'd1,
        SRC_FROM_BUS = 2'd2,
        SRC_CLASH    = 2'd3
    } src_e;

endpackage

// File: rtl/flag_derive.sv
module flag_derive #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              carry_in,
    output status_flags_pkg::flags_t flags
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        flags.carry = carry_in;
        flags.zero  = (result == '0);
        flags.neg   = result[MSB];
        flags.eq    = (opa == opb);
    end
endmodule

// File: rtl/flag_src_sel.sv
module flag_src_sel (
    input  logic alu_load,
    input  logic bus_load,
    output status_flags_pkg::src_e sel,
    output logic conflict
);
    import status_flags_pkg::*;

    always_comb begin
        unique case ({alu_load, bus_load})
            2'b00:   sel = SRC_HOLD;
            2'b10:   sel = SRC_FROM_ALU;
            2'b01:   sel = SRC_FROM_BUS;
            default: sel = SRC_CLASH;
        endcase
    end

    always_comb begin
        unique case (sel)
            SRC_CLASH:    conflict = 1'b1;
            SRC_HOLD,
            SRC_FROM_ALU,
            SRC_FROM_BUS: conflict = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_store.sv
module flag_store (
    input  logic clk,
    input  logic rst,
    input  status_flags_pkg::src_e sel,
    input  status_flags_pkg::flags_t alu_flags,
    input  status_flags_pkg::flags_t bus_flags,
    output status_flags_pkg::flags_t q
);
    import status_flags_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (sel)
                SRC_FROM_ALU: q <= alu_flags;
                SRC_FROM_BUS: q <= bus_flags;
                SRC_HOLD,
                SRC_CLASH:    q <= q;
            endcase
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_bus_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_FROM_BUS) |=> (q == $past(bus_flags)));

    assert_clash_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_CLASH) |=> $stable(q));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_HOLD) |=> $stable(q));
endmodule

// File: rtl/status_flags.sv
module status_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_load,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [DATA_W-1:0] alu_opa,
    input  logic [DATA_W-1:0] alu_opb,
    input  logic              alu_carry,
    input  logic              bus_load,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              flag_drive,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [3:0]        flags_out,
    output logic              carry_to_alu,
    output logic              conflict
);
    import status_flags_pkg::*;

    localparam int PAD_W = DATA_W - FLAG_W;

    flags_t derived;
    flags_t from_bus;
    flags_t stored;
    src_e   sel;
    logic   unused_bus_hi;

    assign from_bus      = flags_t'(bus_in[FLAG_W-1:0]);
    assign unused_bus_hi = ^bus_in[DATA_W-1:FLAG_W];

    flag_derive #(.DATA_W(DATA_W)) u_derive (
        .result   (alu_result),
        .opa      (alu_opa),
        .opb      (alu_opb),
        .carry_in (alu_carry),
        .flags    (derived)
    );

    flag_src_sel u_sel (
        .alu_load (alu_load),
        .bus_load (bus_load),
        .sel      (sel),
        .conflict (conflict)
    );

    flag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .alu_flags (derived),
        .bus_flags (from_bus),
        .q         (stored)
    );

    always_comb begin
        flags_out    = stored;
        carry_to_alu = stored.carry;
        bus_oe       = flag_drive;
        bus_out      = flag_drive ? {{PAD_W{1'b0}}, stored} : '0;
    end

    assert_alu_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (alu_load && !bus_load) |=> (flags_out[1] == ($past(alu_result) == '0)));

    assert_alu_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (alu_load && !bus_load) |=> (carry_to_alu == $past(alu_carry)));

    assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !flag_drive |-> (bus_out == '0 && !bus_oe));

    assert_drive_no_touch_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_drive && !alu_load && !bus_load) |=> $stable(flags_out));
endmodule

// File: tb/status_flags_bench.sv
module status_flags_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alu_load = 1'b0, bus_load = 1'b0, flag_drive = 1'b0, alu_carry = 1'b0;
    logic [7:0] alu_result = '0, alu_opa = '0, alu_opb = '0, bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe, carry_to_alu, conflict;
    logic [3:0] flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [3:0] model = '0;

    always #4 clk = ~clk;

    status_flags u_status_flags (
        .clk(clk), .rst(rst), .alu_load(alu_load), .alu_result(alu_result),
        .alu_opa(alu_opa), .alu_opb(alu_opb), .alu_carry(alu_carry),
        .bus_load(bus_load), .bus_in(bus_in), .flag_drive(flag_drive),
        .bus_out(bus_out), .bus_oe(bus_oe), .flags_out(flags_out),
        .carry_to_alu(carry_to_alu), .conflict(conflict)
    );

    function automatic logic [3:0] exp_alu(input logic [7:0] r, a, b, input logic c);
        return {a == b, r[7], r == 8'h00, c};
    endfunction

    function automatic logic [3:0] next_model(input logic [3:0] cur);
        if (alu_load && !bus_load) return exp_alu(alu_result, alu_opa, alu_opb, alu_carry);
        if (bus_load && !alu_load) return bus_in[3:0];
        return cur;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational outputs, clock, then check state
    task automatic step(input logic al, input logic bl, input logic dr,
                        input logic [7:0] r, a, b, bi, input logic c);
        alu_load = al; bus_load = bl; flag_drive = dr;
        alu_result = r; alu_opa = a; alu_opb = b; bus_in = bi; alu_carry = c;
        #1;
        check("R4 conflict", {7'b0, conflict}, {7'b0, al & bl});
        check("R6 bus_out", bus_out, dr ? {4'b0, model} : 8'h00);
        check("R6 bus_oe", {7'b0, bus_oe}, {7'b0, dr});
        model = next_model(model);
        @(posedge clk);
        @(negedge clk);
        check("R2/R3/R5 flags", {4'b0, flags_out}, {4'b0, model});
        check("R7 carry", {7'b0, carry_to_alu}, {7'b0, model[0]});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // preload nonzero flags via bus, then R1 reset
        rst = 1'b0;
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 8'h0F, 0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        model = '0;
        check("R1 reset", {4'b0, flags_out}, 8'h00);
        rst = 1'b0;
        // R2 directed: zero result, equal operands, carry set -> 4'b1011
        step(1, 0, 0, 8'h00, 8'h5A, 8'h5A, 8'h00, 1);
        check("R7 layout", {4'b0, flags_out}, 8'h0B);
        // R2 negative, not equal, no carry -> 4'b0100
        step(1, 0, 1, 8'h80, 8'h01, 8'h02, 8'h00, 0);
        check("R7 layout neg", {4'b0, flags_out}, 8'h04);
        // R3 upper bits ignored
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 8'hF9, 0);
        check("R3 low nibble", {4'b0, flags_out}, 8'h09);
        // R4 clash holds
        step(1, 1, 1, 8'h00, 8'h33, 8'h33, 8'h06, 0);
        check("R4 hold", {4'b0, flags_out}, 8'h09);
        // R6 drive alone does not alter
        step(0, 0, 1, 8'hFF, 8'h00, 8'h00, 8'hFF, 1);
        check("R6 no touch", {4'b0, flags_out}, 8'h09);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, b, r;
            a = 8'($urandom);
            b = ($urandom % 4 == 0) ? a : 8'($urandom);
            r = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
            step(1'($urandom), 1'($urandom), 1'($urandom), r, a, b, 8'($urandom), 1'($urandom));
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule